// File: doc/BRIEF.md
# Three-channel clear-on-read interval timer

This block holds three independent interval timers for an audio processor's register page. Each timer divides its own external prescaler tick by a programmable 8-bit period and accumulates the number of elapsed periods in a 4-bit count. Software reads that count, and the read empties it, so each read reports the periods that passed since the previous read.

Accesses use a 4-bit offset within the register page. A control byte at offset 0x1 switches each timer on or off. Offsets 0xA to 0xC hold the periods. Offsets 0xD to 0xF return the counts. Turning a timer on from the off state restarts it from zero. Read data is registered and appears one clock after the read strobe.

Top module: `tri_timer`

## Requirements
- R1: After a synchronous reset, every timer is off, with period, phase counter and output count at zero, and `rd_data` is 0.
- R2: Bit i of a write to offset 0x1 switches timer i on (1) or off (0), for i = 0, 1, 2. A timer that is off ignores its ticks and keeps its counters.
- R3: Writes to offsets 0xA, 0xB and 0xC set the 8-bit period of timers 0, 1 and 2.
- R4: Each tick of a timer that is on advances its phase counter by one. When the advanced value equals the period, the phase counter returns to 0 and the output count advances.
- R5: A period of 0 counts as 256 ticks.
- R6: A read at offset 0xD, 0xE or 0xF puts the output count of timer 0, 1 or 2 on `rd_data` in the next cycle and clears that count. A read at any other offset gives 0.
- R7: Switching a timer from off to on clears its phase counter and its output count. Writing 1 to a bit that is already 1 leaves both counters unchanged.
- R8: Writes to offsets 0xD to 0xF, and to offsets the block does not decode, change no timer state.
- R9: When a read and a period completion hit the same timer in the same cycle, the read returns the count from before the completion, and the count afterwards is 1.
- R10: The output count wraps from 15 to 0.
- R11: A read of a timer that is off still returns its count and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 3 | One-cycle prescaler pulse, one bit per timer |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write offset within the register page |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read offset within the register page |
| rd_data | output | 4 | Registered read data, valid the cycle after `rd_en` |

## Verification
A read of a count and the tick that completes a period can land on the same edge. The completion must not be lost to the read clear. The bench sets a timer with a period of one to a known count, then raises the read strobe and that timer's tick in the same cycle. It expects the read to return the old count and the next read to return 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Offset width of the register page and the fixed offsets the bus decodes.
  localparam int unsigned REG_AW   = 4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h1;
  localparam logic [REG_AW-1:0] OFS_TGT0 = 4'hA;
  localparam logic [REG_AW-1:0] OFS_OUT0 = 4'hD;

  typedef logic [REG_AW-1:0] reg_ofs_t;
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = 3
) (
  input  logic               wr_en,
  input  reg_ofs_t           wr_addr,
  input  logic               rd_en,
  input  reg_ofs_t           rd_addr,
  output logic               ctl_we,
  output logic [NUM_TMR-1:0] tgt_we,
  output logic [NUM_TMR-1:0] rd_hit
);
  assign ctl_we = wr_en && (wr_addr == OFS_CTRL);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    localparam reg_ofs_t TGT_OFS = reg_ofs_t'(OFS_TGT0 + i);
    localparam reg_ofs_t OUT_OFS = reg_ofs_t'(OFS_OUT0 + i);
    assign tgt_we[i] = wr_en && (wr_addr == TGT_OFS);
    assign rd_hit[i] = rd_en && (rd_addr == OUT_OFS);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctl_we,
  input  logic             ctl_bit,
  input  logic             tgt_we,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_hit,
  output logic [OUT_W-1:0] out_cnt
);
  localparam logic [OUT_W-1:0] OUT_ONE = OUT_W'(1);

  logic             en_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] stg_q;
  logic [OUT_W-1:0] out_q;
  logic [CNT_W-1:0] stg_nxt;
  logic             step;
  logic             wrap;
  logic             en_rise;

  // The phase counter wraps at 2**CNT_W, so a period of zero needs no extra bit.
  assign stg_nxt = stg_q + 1'b1;
  assign step    = tick && en_q;
  assign wrap    = step && (stg_nxt == tgt_q);
  assign en_rise = ctl_we && ctl_bit && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      tgt_q <= '0;
      stg_q <= '0;
      out_q <= '0;
    end else begin
      if (ctl_we) en_q  <= ctl_bit;
      if (tgt_we) tgt_q <= wr_data;
      if (en_rise) begin
        stg_q <= '0;
        out_q <= '0;
      end else begin
        if (step) stg_q <= wrap ? '0 : stg_nxt;
        if (rd_hit)    out_q <= wrap ? OUT_ONE : '0;
        else if (wrap) out_q <= out_q + 1'b1;
      end
    end
  end

  assign out_cnt = out_q;

  // R7
  rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (stg_q == '0) && (out_q == '0));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !wrap && !en_rise) |=> (out_q == '0));

  // R9
  read_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && wrap && !en_rise) |=> (out_q == OUT_ONE));

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !rd_hit && !ctl_we) |=> ($stable(out_q) && $stable(stg_q)));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap && !en_rise) |=> (stg_q == $past(stg_q) + 1'b1));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OUT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TMR-1:0] tick,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [OUT_W-1:0]   rd_data
);
  localparam int unsigned CNT_W = DATA_W;

  logic               ctl_we;
  logic [NUM_TMR-1:0] tgt_we;
  logic [NUM_TMR-1:0] rd_hit;
  logic [OUT_W-1:0]   out_cnt [NUM_TMR];
  logic [OUT_W-1:0]   rd_sel;

  tmr_dec #(.NUM_TMR(NUM_TMR)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .ctl_we  (ctl_we),
    .tgt_we  (tgt_we),
    .rd_hit  (rd_hit)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick[i]),
      .ctl_we  (ctl_we),
      .ctl_bit (wr_data[i]),
      .tgt_we  (tgt_we[i]),
      .wr_data (wr_data[CNT_W-1:0]),
      .rd_hit  (rd_hit[i]),
      .out_cnt (out_cnt[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (rd_hit[i]) rd_sel = rd_sel | out_cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  // R6
  foreign_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_hit == '0)) |=> (rd_data == '0));

  // R6
  one_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_hit));
endmodule

// File: tb/sim_tri_timer.sv
module sim_tri_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] tick;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [3:0] rd_addr;
  logic [3:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tri_timer u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick = m;
      @(posedge clk); @(negedge clk);
    end
    tick = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [2:0] m, output int v);
    rd_en = 1'b1; rd_addr = a; tick = m;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; tick = '0;
    v = int'(rd_data);
  endtask

  task automatic t_reset();
    int v;
    check("R1 rd_data after reset", int'(rd_data), 0);
    rd(4'hD, 3'b000, v);
    check("R1 count 0 after reset", v, 0);
  endtask

  task automatic t_map();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hA, 8'd1); wr(4'hB, 8'd2); wr(4'hC, 8'd4);
    wr(4'h1, 8'h07);
    pulse(3'b111, 4);
    rd(4'hD, 3'b000, v); check("R3 R4 timer0 period 1", v, 4);
    rd(4'hE, 3'b000, v); check("R3 R4 timer1 period 2", v, 2);
    rd(4'hF, 3'b000, v); check("R3 R4 timer2 period 4", v, 1);
    rd(4'hD, 3'b000, v); check("R6 reread after clear", v, 0);
  endtask

  task automatic t_wrap();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hA, 8'd1);
    wr(4'h1, 8'h01);
    pulse(3'b001, 17);
    rd(4'hD, 3'b000, v); check("R10 wrap 15 to 0", v, 1);
  endtask

  task automatic t_zero();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hB, 8'd0);
    wr(4'h1, 8'h02);
    pulse(3'b010, 255);
    rd(4'hE, 3'b000, v); check("R5 period 0 after 255 ticks", v, 0);
    pulse(3'b010, 1);
    rd(4'hE, 3'b000, v); check("R5 period 0 after 256 ticks", v, 1);
  endtask

  task automatic t_rewrite();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hA, 8'd2);
    wr(4'h1, 8'h01);
    pulse(3'b001, 3);
    wr(4'h1, 8'h01);
    pulse(3'b001, 1);
    rd(4'hD, 3'b000, v); check("R7 rewrite of set enable keeps counters", v, 2);
    pulse(3'b001, 2);
    wr(4'h1, 8'h00);
    wr(4'h1, 8'h01);
    rd(4'hD, 3'b000, v); check("R7 enable rise clears count", v, 0);
  endtask

  task automatic t_ignore();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hC, 8'd1);
    wr(4'h1, 8'h04);
    pulse(3'b100, 3);
    wr(4'hF, 8'hFF); wr(4'hD, 8'h00); wr(4'h0, 8'hFF); wr(4'h8, 8'hFF);
    pulse(3'b100, 1);
    rd(4'hF, 3'b000, v); check("R8 writes to counts and gaps ignored", v, 4);
    rd(4'h2, 3'b000, v); check("R6 undecoded read gives 0", v, 0);
  endtask

  task automatic t_hold();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hC, 8'd2);
    wr(4'h1, 8'h04);
    pulse(3'b100, 5);
    wr(4'h1, 8'h00);
    pulse(3'b100, 6);
    rd(4'hF, 3'b000, v); check("R2 R11 off timer holds and reads", v, 2);
    rd(4'hF, 3'b000, v); check("R11 off timer read clears", v, 0);
  endtask

  task automatic t_collide();
    int v;
    wr(4'h1, 8'h00);
    wr(4'hB, 8'd1);
    wr(4'h1, 8'h02);
    pulse(3'b010, 3);
    rd(4'hE, 3'b010, v); check("R9 read with completion returns old", v, 3);
    rd(4'hE, 3'b000, v); check("R9 completion kept after clear", v, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_wrap();
    t_zero();
    t_rewrite();
    t_ignore();
    t_hold();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule